// File: doc/BRIEF.md
# Address Window Decoder for a Single-Master Bus

This block sits between one bus master and a set of slave devices on a bus with a cycle/acknowledge handshake. Each slave is given a mask word and a match word. The block compares the master address against every pair, then forwards the master's cycle request to the one slave that claims the address. It returns that slave's acknowledge and read data to the master.

Several windows may claim the same address. In that case the slave with the smallest index takes the access, so a catch-all window can sit at a high index behind narrower ones. An address that no window claims is answered at once with an acknowledge and zero read data, so the master never waits on a device that does not exist.

The path holds no state. Outputs follow the inputs in the same cycle. Strobe, write enable, write data and the address itself go to all slaves in common and do not pass through this block.

Top module: `bus_window_decoder`

## Requirements
- R1: Slave i claims the address when (address AND mask i) equals match i. The compare covers every address bit, including bit 31.
- R2: While the master cycle input is low, every slave cycle output is low and the master acknowledge is low, whatever the address and slave acknowledges.
- R3: While the master cycle input is high, only the selected slave's cycle output is high and all others are low. At most one slave cycle output is ever high.
- R4: When more than one window claims the address, the lowest-indexed claiming slave is selected.
- R5: During a mapped access, the master acknowledge equals the selected slave's acknowledge. Acknowledges from slaves that are not selected have no effect on it.
- R6: During a mapped access, the master read data equals the selected slave's read data.
- R7: When the master cycle input is high and no window claims the address, no slave cycle output is high and the master acknowledge is high.
- R8: When no window claims the address, the master read data is all zeros.
- R9: All outputs settle within the same cycle as an address or cycle change. No clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_cyc_i | input | 1 | Master cycle request |
| m_adr_i | input | AW (32) | Master address |
| m_ack_o | output | 1 | Acknowledge returned to the master |
| m_rdata_o | output | DW (8) | Read data returned to the master |
| win_mask_i | input | N_SLV x AW | Per-slave mask words, index 0 first |
| win_match_i | input | N_SLV x AW | Per-slave match words |
| s_cyc_o | output | N_SLV | Per-slave cycle request |
| s_ack_i | input | N_SLV | Per-slave acknowledge |
| s_rdata_i | input | N_SLV x DW | Per-slave read data |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between input and output. The bench changes inputs on the falling clock edge and samples 1 ns later, well before the next rising edge, so no clock edge lies between stimulus and sample. One task changes the address twice within a single half period and checks after each change. This shows the outputs follow without any edge.

// File: rtl/bwd_pkg.sv
// Package: shared defaults and the outcome type of the address window decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package bwd_pkg;

    localparam int unsigned DEF_N_SLV = 5;
    localparam int unsigned DEF_AW    = 32;
    localparam int unsigned DEF_DW    = 8;

    // Outcome of one decode: no request, a claimed window, or a miss.
    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_HIT  = 2'd1,
        DEC_MISS = 2'd2
    } dec_kind_e;

endpackage : bwd_pkg

// File: rtl/bwd_window_cmp.sv
// Module: bwd_window_cmp
// Compares one address against N_SLV mask/match pairs and flags each pair
// that claims it. Assumes mask and match are stable during an access.
module bwd_window_cmp #(
    parameter int unsigned N_SLV = 5,
    parameter int unsigned AW    = 32
) (
    input  logic [AW-1:0]            adr_i,
    input  logic [N_SLV-1:0][AW-1:0] mask_i,
    input  logic [N_SLV-1:0][AW-1:0] match_i,
    output logic [N_SLV-1:0]         hit_o
);

    for (genvar gi = 0; gi < N_SLV; gi++) begin : g_win
        // Flag slave gi when the masked address equals its match word.
        always_comb begin
            hit_o[gi] = ((adr_i & mask_i[gi]) == match_i[gi]);
        end
    end

endmodule : bwd_window_cmp

// File: rtl/bwd_prio_pick.sv
// Module: bwd_prio_pick
// Reduces a hit vector to a one-hot grant, keeping the lowest set index.
// Assumes nothing about how many hits are set.
module bwd_prio_pick #(
    parameter int unsigned N_SLV = 5
) (
    input  logic [N_SLV-1:0] hit_i,
    output logic [N_SLV-1:0] grant_o,
    output logic             any_o
);

    logic [N_SLV:0] taken;

    assign taken[0] = 1'b0;

    for (genvar gi = 0; gi < N_SLV; gi++) begin : g_chain
        // Grant slot gi only when no lower slot has already been granted.
        always_comb begin
            grant_o[gi]   = hit_i[gi] & ~taken[gi];
            taken[gi + 1] = taken[gi] | hit_i[gi];
        end
    end

    // Report whether any slot was granted.
    always_comb begin
        any_o = taken[N_SLV];
    end

endmodule : bwd_prio_pick

// File: rtl/bwd_resp_mux.sv
// Module: bwd_resp_mux
// AND-OR multiplexer that returns the acknowledge and read data of the
// granted slave. Assumes the grant is one-hot or zero; zero gives zeros.
module bwd_resp_mux #(
    parameter int unsigned N_SLV = 5,
    parameter int unsigned DW    = 8
) (
    input  logic [N_SLV-1:0]         grant_i,
    input  logic [N_SLV-1:0]         ack_i,
    input  logic [N_SLV-1:0][DW-1:0] rdata_i,
    output logic                     ack_o,
    output logic [DW-1:0]            rdata_o
);

    // Merge the granted slave's response. Ungranted slots contribute nothing.
    always_comb begin
        ack_o   = 1'b0;
        rdata_o = '0;
        for (int i = 0; i < N_SLV; i++) begin
            ack_o   = ack_o | (grant_i[i] & ack_i[i]);
            rdata_o = rdata_o | (rdata_i[i] & {DW{grant_i[i]}});
        end
    end

endmodule : bwd_resp_mux

// File: rtl/bus_window_decoder.sv
// Module: bus_window_decoder
// Combinational address decoder and response multiplexer for one master and
// N_SLV slaves. The lowest-indexed claiming window wins. A miss is
// acknowledged at once with zero data. Assumes a single master. Strobe,
// write enable and write data are fanned out outside this block.
module bus_window_decoder
    import bwd_pkg::*;
#(
    parameter int unsigned N_SLV = DEF_N_SLV,
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned DW    = DEF_DW
) (
    input  logic                     m_cyc_i,
    input  logic [AW-1:0]            m_adr_i,
    output logic                     m_ack_o,
    output logic [DW-1:0]            m_rdata_o,
    input  logic [N_SLV-1:0][AW-1:0] win_mask_i,
    input  logic [N_SLV-1:0][AW-1:0] win_match_i,
    output logic [N_SLV-1:0]         s_cyc_o,
    input  logic [N_SLV-1:0]         s_ack_i,
    input  logic [N_SLV-1:0][DW-1:0] s_rdata_i
);

    logic [N_SLV-1:0] hit;
    logic [N_SLV-1:0] grant;
    logic             any_hit;
    logic             sel_ack;
    dec_kind_e        kind;

    bwd_window_cmp #(.N_SLV(N_SLV), .AW(AW)) cmp_i (
        .adr_i   (m_adr_i),
        .mask_i  (win_mask_i),
        .match_i (win_match_i),
        .hit_o   (hit)
    );

    bwd_prio_pick #(.N_SLV(N_SLV)) pick_i (
        .hit_i   (hit),
        .grant_o (grant),
        .any_o   (any_hit)
    );

    bwd_resp_mux #(.N_SLV(N_SLV), .DW(DW)) mux_i (
        .grant_i (grant),
        .ack_i   (s_ack_i),
        .rdata_i (s_rdata_i),
        .ack_o   (sel_ack),
        .rdata_o (m_rdata_o)
    );

    // Classify the current access.
    always_comb begin
        if (!m_cyc_i)     kind = DEC_IDLE;
        else if (any_hit) kind = DEC_HIT;
        else              kind = DEC_MISS;
    end

    // Gate slave requests with the master cycle. Absorb a miss with an acknowledge.
    always_comb begin
        s_cyc_o = grant & {N_SLV{m_cyc_i}};
        unique case (kind)
            DEC_HIT:  m_ack_o = sel_ack;
            DEC_MISS: m_ack_o = 1'b1;
            default:  m_ack_o = 1'b0;
        endcase
    end

    // Output-level checks on the settled combinational result.
    always_comb begin
        // R3
        one_cyc_chk: assert ($onehot0(s_cyc_o));
        // R2
        if (!m_cyc_i) begin
            idle_quiet_chk: assert (s_cyc_o == '0 && !m_ack_o);
        end
        // R7
        if (m_cyc_i && s_cyc_o == '0) begin
            miss_ack_chk: assert (m_ack_o);
        end
        // R8
        if (hit == '0) begin
            miss_zero_chk: assert (m_rdata_o == '0);
        end
    end

    for (genvar gi = 0; gi < N_SLV; gi++) begin : g_resp_chk
        // Response of a requested slave must reach the master unchanged.
        always_comb begin
            if (s_cyc_o[gi]) begin
                // R5
                sel_ack_chk: assert (m_ack_o == s_ack_i[gi]);
                // R6
                sel_data_chk: assert (m_rdata_o == s_rdata_i[gi]);
            end
        end
    end

endmodule : bus_window_decoder

// File: tb/bus_window_decoder_tb_top.sv
// Directed bench for bus_window_decoder: one task per scenario.
module bus_window_decoder_tb_top;

    localparam int N  = 5;
    localparam int AW = 32;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic                 m_cyc   = 1'b0;
    logic [AW-1:0]        m_adr   = '0;
    logic                 m_ack;
    logic [DW-1:0]        m_rdata;
    logic [N-1:0][AW-1:0] wmask;
    logic [N-1:0][AW-1:0] wmatch;
    logic [N-1:0]         s_cyc;
    logic [N-1:0]         s_ack   = '0;
    logic [N-1:0][DW-1:0] s_rdata;

    int errors = 0;
    int checks = 0;

    bus_window_decoder #(.N_SLV(N), .AW(AW), .DW(DW)) dut_i (
        .m_cyc_i     (m_cyc),
        .m_adr_i     (m_adr),
        .m_ack_o     (m_ack),
        .m_rdata_o   (m_rdata),
        .win_mask_i  (wmask),
        .win_match_i (wmatch),
        .s_cyc_o     (s_cyc),
        .s_ack_i     (s_ack),
        .s_rdata_i   (s_rdata)
    );

    task automatic load_default_map();
        wmask[0] = 32'h0200_0000; wmatch[0] = 32'h0000_0000;
        wmask[1] = 32'h0200_4000; wmatch[1] = 32'h0200_0000;
        wmask[2] = 32'h0200_4018; wmatch[2] = 32'h0200_4000;
        wmask[3] = 32'h0200_4018; wmatch[3] = 32'h0200_4008;
        wmask[4] = 32'h0200_4018; wmatch[4] = 32'h0200_4010;
        for (int i = 0; i < N; i++) s_rdata[i] = 8'(8'h11 * (i + 1));
    endtask

    // Expected selection from R1 and R4: lowest claiming index, or -1.
    function automatic int exp_sel(logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if ((a & wmask[i]) == wmatch[i]) return i;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs against the value derived from the requirements.
    task automatic expect_now(string req, logic cyc, logic [AW-1:0] a, logic [N-1:0] acks);
        int sel;
        logic [N-1:0] e_cyc;
        logic e_ack;
        logic [DW-1:0] e_dat;
        sel   = exp_sel(a);
        e_cyc = (cyc && sel >= 0) ? N'(1) << sel : '0;
        e_ack = !cyc ? 1'b0 : (sel < 0 ? 1'b1 : acks[sel]);
        e_dat = (sel < 0) ? '0 : s_rdata[sel];
        check({req, " s_cyc"}, 32'(s_cyc), 32'(e_cyc));
        check({req, " m_ack"}, 32'(m_ack), 32'(e_ack));
        check({req, " m_rdata"}, 32'(m_rdata), 32'(e_dat));
    endtask

    // Drive on the falling edge, sample 1 ns later: zero register stages (R9).
    task automatic apply(string req, logic cyc, logic [AW-1:0] a, logic [N-1:0] acks);
        @(negedge clk);
        m_cyc = cyc; m_adr = a; s_ack = acks;
        #1;
        expect_now(req, cyc, a, acks);
    endtask

    // R2: no request means no slave cycle and no acknowledge.
    task automatic t_idle();
        apply("R2 idle slave0", 1'b0, 32'h0000_0000, '1);
        apply("R2 idle slave3", 1'b0, 32'h0200_4008, '1);
        apply("R2 idle unmapped", 1'b0, 32'h0200_4018, '1);
    endtask

    // R1 R3 R5 R6: each window edge and middle, with only the owner acknowledging.
    task automatic t_hits();
        logic [AW-1:0] addrs [15] = '{
            32'h0000_0000, 32'h0000_1000, 32'h01FF_FFFF,
            32'h0200_0000, 32'h0200_1000, 32'h0200_3FFF,
            32'h0200_4000, 32'h0200_4003, 32'h0200_4007,
            32'h0200_4008, 32'h0200_400B, 32'h0200_400F,
            32'h0200_4010, 32'h0200_4013, 32'h0200_4017};
        for (int k = 0; k < 15; k++) begin
            int s;
            s = exp_sel(addrs[k]);
            check("R1 window owner", 32'(s), 32'(k / 3));
            apply("R1 R3 R5 R6 owner acks", 1'b1, addrs[k], N'(1) << s);
            apply("R5 foreign acks ignored", 1'b1, addrs[k], ~(N'(1) << s));
        end
    endtask

    // R7 R8: unmapped addresses are absorbed with zero data.
    task automatic t_unmapped();
        apply("R7 R8 miss 0x02004018", 1'b1, 32'h0200_4018, '0);
        apply("R7 R8 miss 0x0200401F", 1'b1, 32'h0200_401F, '1);
        apply("R7 R8 miss 0x03FFFFFF", 1'b1, 32'h03FF_FFFF, '0);
    endtask

    // R4: overlapping windows resolve to the lowest index.
    task automatic t_overlap();
        wmask[3] = '0; wmatch[3] = '0;
        wmask[4] = '0; wmatch[4] = '0;
        apply("R4 slave0 beats catch-all", 1'b1, 32'h0000_0010, 5'b11001);
        check("R4 slave0 selected", 32'(s_cyc), 32'h1);
        apply("R4 catch-all 3 beats 4", 1'b1, 32'h0200_4018, 5'b10000);
        check("R4 slave3 selected", 32'(s_cyc), 32'h8);
        load_default_map();
    endtask

    // R1: the top address bit is part of the compare.
    task automatic t_full_width();
        wmask[0] = 32'h8200_0000;
        apply("R1 bit31 excludes", 1'b1, 32'h8000_0000, '0);
        check("R1 bit31 miss", 32'(s_cyc), 32'h0);
        apply("R1 bit31 clear hits", 1'b1, 32'h0000_0001, 5'b00001);
        load_default_map();
    endtask

    // R9: two address changes inside one half period, each settled at once.
    task automatic t_same_cycle();
        @(negedge clk);
        m_cyc = 1'b1; s_ack = 5'b00100; m_adr = 32'h0200_4004;
        #0.5;
        expect_now("R9 first change", 1'b1, m_adr, s_ack);
        m_adr = 32'h0200_0004;
        #0.5;
        expect_now("R9 second change", 1'b1, m_adr, s_ack);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        load_default_map();
        #1;
        // Reset state: idle inputs give quiet outputs (R2).
        check("R2 start s_cyc", 32'(s_cyc), 32'h0);
        check("R2 start m_ack", 32'(m_ack), 32'h0);
        t_idle();
        t_hits();
        t_unmapped();
        t_overlap();
        t_full_width();
        t_same_cycle();
        apply("R2 back to idle", 1'b0, 32'h0200_4010, '1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule : bus_window_decoder_tb_top